// File: doc/BRIEF.md
# Programmable External Reset Pulse Generator

This block turns a single-cycle expiry event from a watchdog counter into a reset pulse on an external pin. The pulse length is programmed in microseconds and timed by a 1 MHz tick that the system provides. The pin can be set to assert high or low. It can also drive both levels (push-pull) or drive only its active level and otherwise float (open-drain).

Software reaches the block through one 32-bit configuration register. The low 20 bits hold the pulse length minus one, and any write updates them. The polarity and drive-mode settings are protected by keys. They change only when the most significant byte of a write holds one of four key values, so a plain write of a new length cannot flip the pin's electrical behaviour by accident. The two settings read back as single flag bits at the top of the register.

Top module: `rst_pulse_gen`

## Requirements
- R1: After reset the register reads 0x000000FF (active-low, open-drain, length field 0xFF). The pin is released: pinOe is 0 and pinOut is 1.
- R2: Every register write loads bits 19:0 into the length field. Bits 29:20 always read as 0.
- R3: When the length field holds N at the moment of expiry, the pin holds its active level during exactly N+1 tick cycles. The pulse starts in the cycle after the expiry strobe and ends in the cycle after the (N+1)th tick. The default N=0xFF gives 256 ticks.
- R4: A write with top byte 0xA5 makes the pin active-high, and register bit 31 then reads 1. A write with top byte 0x5A makes the pin active-low, and bit 31 then reads 0.
- R5: A write with top byte 0xA8 selects push-pull drive, and register bit 30 then reads 1. A write with top byte 0x8A selects open-drain drive, and bit 30 then reads 0.
- R6: A write whose top byte is not one of the four keys leaves bits 31 and 30 unchanged. It still updates the length field.
- R7: In open-drain mode pinOe is 1 only during a pulse. In push-pull mode pinOe is always 1 and the idle pin sits at the inactive level.
- R8: An expiry strobe that arrives while a pulse is running has no effect. The pulse does not restart or lengthen, and no second pulse follows.
- R9: The pulse length is taken when the pulse starts. A register write during a pulse does not change the length of that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Configuration register write strobe |
| regWrData | input | 32 | Data written to the configuration register |
| regRdData | output | 32 | Current configuration register contents |
| tick | input | 1 | One-cycle strobe every microsecond |
| expire | input | 1 | One-cycle watchdog expiry strobe |
| pinOut | output | 1 | Level presented to the reset pin |
| pinOe | output | 1 | Output enable for the reset pin |

## Verification
A down-counter that loads the wrong value or misses a step shows up as a pulse that is off by whole ticks. It is therefore measured in ticks from the first active sample until release, and the result is known when each pulse ends. A flag register that a non-key byte corrupts appears in the readback one cycle after the write. It also appears at once as a wrong idle level or output enable on the pin. A controller that re-arms on a second expiry produces a longer pulse or an extra pulse. The bench catches this during the quiet window after each pulse.

// File: rtl/rst_pulse_pkg.sv
package rst_pulse_pkg;
  localparam logic [7:0] KEY_ACT_HIGH   = 8'hA5;
  localparam logic [7:0] KEY_ACT_LOW    = 8'h5A;
  localparam logic [7:0] KEY_PUSH_PULL  = 8'hA8;
  localparam logic [7:0] KEY_OPEN_DRAIN = 8'h8A;

  // strobes from the controller into the datapath
  typedef struct packed {
    logic load;    // capture the length into the down-counter
    logic step;    // decrement on a tick
    logic finish;  // last tick of the pulse
  } pulseCtl_t;
endpackage

// File: rtl/rst_pulse_ctrl.sv
module rst_pulse_ctrl
  import rst_pulse_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      expire,
  input  logic      tick,
  input  logic      cntZero,
  output pulseCtl_t ctl,
  output logic      busy
);
  typedef enum logic {IDLE, DRIVE} state_t;
  state_t stateQ, stateD;

  always_comb begin
    ctl        = '0;
    stateD     = stateQ;
    ctl.load   = (stateQ == IDLE) && expire;
    ctl.step   = (stateQ == DRIVE) && tick && !cntZero;
    ctl.finish = (stateQ == DRIVE) && tick && cntZero;
    if (ctl.load)   stateD = DRIVE;
    if (ctl.finish) stateD = IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= IDLE;
    else       stateQ <= stateD;
  end

  assign busy = (stateQ == DRIVE);

  // R3: the pulse is released right after its last tick
  a_r3_release: assert property (@(posedge clk) disable iff (!rstN)
    ctl.finish |=> !busy);
  // R8: an expiry inside a pulse does not restart it
  a_r8_no_rearm: assert property (@(posedge clk) disable iff (!rstN)
    busy && expire |-> !ctl.load);
endmodule

// File: rtl/rst_pulse_dp.sv
module rst_pulse_dp
  import rst_pulse_pkg::*;
#(
  parameter int REG_BITS      = 32,
  parameter int WIDTH_BITS    = 20,
  parameter logic [WIDTH_BITS-1:0] DEFAULT_LEN = 'hFF
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [REG_BITS-1:0] regWrData,
  output logic [REG_BITS-1:0] regRdData,
  input  pulseCtl_t           ctl,
  input  logic                busy,
  output logic                cntZero,
  output logic                pinOut,
  output logic                pinOe
);
  localparam int PAD_BITS = REG_BITS - 2 - WIDTH_BITS;
  localparam int GAP_BITS = REG_BITS - 8 - WIDTH_BITS;

  logic [WIDTH_BITS-1:0] lenQ;
  logic [WIDTH_BITS-1:0] cntQ;
  logic                  actHighQ;
  logic                  pushPullQ;
  logic [7:0]            keyByte;

  assign keyByte = regWrData[REG_BITS-1 -: 8];

  generate
    if (GAP_BITS > 0) begin : g_gap
      logic wrUnused;
      assign wrUnused = ^regWrData[REG_BITS-9:WIDTH_BITS];
    end
  endgenerate

  // guarded configuration register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenQ      <= DEFAULT_LEN;
      actHighQ  <= 1'b0;
      pushPullQ <= 1'b0;
    end else if (regWrEn) begin
      lenQ <= regWrData[WIDTH_BITS-1:0];
      case (keyByte)
        KEY_ACT_HIGH:   actHighQ  <= 1'b1;
        KEY_ACT_LOW:    actHighQ  <= 1'b0;
        KEY_PUSH_PULL:  pushPullQ <= 1'b1;
        KEY_OPEN_DRAIN: pushPullQ <= 1'b0;
        default: ;
      endcase
    end
  end

  assign regRdData = {actHighQ, pushPullQ, {PAD_BITS{1'b0}}, lenQ};

  // pulse down-counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         cntQ <= '0;
    else if (ctl.load) cntQ <= lenQ;
    else if (ctl.step) cntQ <= cntQ - 1'b1;
  end

  assign cntZero = (cntQ == '0);

  // pin drive
  assign pinOut = busy ? actHighQ : !actHighQ;
  assign pinOe  = pushPullQ || busy;

  // R2: each write lands in the length field
  a_r2_len_write: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> lenQ == $past(regWrData[WIDTH_BITS-1:0]));
  // R3: the counter starts from the programmed length
  a_r3_load_len: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> cntQ == $past(lenQ));
  // R9: the counter moves only on load or on a tick
  a_r9_count_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load && !ctl.step |=> $stable(cntQ));
  // R4: the high-polarity key sets the flag
  a_r4_key_high: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn && keyByte == KEY_ACT_HIGH |=> actHighQ);
  // R6: other top bytes leave both flags alone
  a_r6_no_key: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn && keyByte != KEY_ACT_HIGH && keyByte != KEY_ACT_LOW &&
    keyByte != KEY_PUSH_PULL && keyByte != KEY_OPEN_DRAIN
    |=> $stable(actHighQ) && $stable(pushPullQ));
  // R7: open-drain only enables the pin during a pulse
  a_r7_od_release: assert property (@(posedge clk) disable iff (!rstN)
    pinOe && !pushPullQ |-> busy && pinOut == actHighQ);
endmodule

// File: rtl/rst_pulse_gen.sv
module rst_pulse_gen
  import rst_pulse_pkg::*;
#(
  parameter int REG_BITS   = 32,
  parameter int WIDTH_BITS = 20
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [REG_BITS-1:0] regWrData,
  output logic [REG_BITS-1:0] regRdData,
  input  logic                tick,
  input  logic                expire,
  output logic                pinOut,
  output logic                pinOe
);
  pulseCtl_t ctl;
  logic      busy;
  logic      cntZero;

  rst_pulse_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .expire  (expire),
    .tick    (tick),
    .cntZero (cntZero),
    .ctl     (ctl),
    .busy    (busy)
  );

  rst_pulse_dp #(
    .REG_BITS   (REG_BITS),
    .WIDTH_BITS (WIDTH_BITS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .ctl       (ctl),
    .busy      (busy),
    .cntZero   (cntZero),
    .pinOut    (pinOut),
    .pinOe     (pinOe)
  );
endmodule

// File: tb/tb_rst_pulse_gen.sv
`timescale 1ns/100ps
module tb_rst_pulse_gen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        tick = 1'b0;
  logic        expire = 1'b0;
  logic        pinOut;
  logic        pinOe;

  int errors = 0;
  int checks = 0;
  int extraPulses = 0;
  bit expHigh = 1'b0;
  int expQ[$];
  string tagQ[$];

  always #2.5 clk = ~clk;

  rst_pulse_gen dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .tick(tick), .expire(expire),
    .pinOut(pinOut), .pinOe(pinOe)
  );

  // tick every third cycle, driven just after the edge
  int tickCnt = 0;
  always @(posedge clk) begin
    #1;
    tickCnt = (tickCnt + 1) % 3;
    tick = (tickCnt == 0);
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wrReg(logic [31:0] d);
    @(posedge clk); #1;
    regWrEn = 1'b1; regWrData = d;
    @(posedge clk); #1;
    regWrEn = 1'b0;
    if (d[31:24] == 8'hA5) expHigh = 1'b1;
    if (d[31:24] == 8'h5A) expHigh = 1'b0;
  endtask

  // driver: expect N+1 ticks, strobe expiry
  task automatic firePulse(string req, int len);
    expQ.push_back(len + 1);
    tagQ.push_back(req);
    @(posedge clk); #1;
    expire = 1'b1;
    @(posedge clk); #1;
    expire = 1'b0;
  endtask

  task automatic waitDone();
    while (expQ.size() != 0) @(posedge clk);
    repeat (10) @(posedge clk);
  endtask

  // monitor: measure active ticks, compare at release
  bit prevAct = 1'b0;
  int seen = 0;
  always @(negedge clk) begin
    bit act;
    act = pinOe && (pinOut == expHigh);
    if (act && tick) seen++;
    if (!act && prevAct) begin
      if (expQ.size() == 0) begin
        extraPulses++;
      end else begin
        check(tagQ.pop_front(), seen, expQ.pop_front());
      end
      seen = 0;
    end
    prevAct = act;
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check("R1 readback", regRdData, 32'h0000_00FF);
    check("R1 pinOe", pinOe, 0);
    check("R1 pinOut", pinOut, 1);

    firePulse("R3 default 256", 255); waitDone();

    wrReg(32'h0000_0003); @(negedge clk);
    check("R2 len", regRdData, 32'h0000_0003);
    wrReg(32'h3FF0_0005); @(negedge clk);
    check("R2 pad zero", regRdData, 32'h0000_0005);
    firePulse("R3 len5", 5); waitDone();

    wrReg(32'hA500_0002); @(negedge clk);
    check("R4 high key", regRdData, 32'h8000_0002);
    check("R7 od idle oe", pinOe, 0);
    firePulse("R3 active-high", 2); waitDone();

    wrReg(32'hA800_0002); @(negedge clk);
    check("R5 pp key", regRdData, 32'hC000_0002);
    check("R7 pp idle oe", pinOe, 1);
    check("R7 pp idle lvl", pinOut, 0);
    firePulse("R7 pp pulse", 2); waitDone();

    wrReg(32'h1200_0007); @(negedge clk);
    check("R6 other byte", regRdData, 32'hC000_0007);
    wrReg(32'hA400_0008); @(negedge clk);
    check("R6 near key", regRdData, 32'hC000_0008);

    wrReg(32'h5A00_0001); @(negedge clk);
    check("R4 low key", regRdData, 32'h4000_0001);
    check("R7 pp idle lvl low", pinOut, 1);
    wrReg(32'h8A00_0000); @(negedge clk);
    check("R5 od key", regRdData, 32'h0000_0000);
    firePulse("R3 len0", 0); waitDone();

    wrReg(32'h0000_0009);
    firePulse("R8 len9", 9);
    repeat (12) @(posedge clk); #1;
    expire = 1'b1;
    @(posedge clk); #1;
    expire = 1'b0;
    waitDone();
    repeat (40) @(posedge clk);
    check("R8 no extra pulse", extraPulses, 0);

    firePulse("R9 latched len", 9);
    repeat (6) @(posedge clk);
    wrReg(32'h0000_0001);
    waitDone();
    @(negedge clk);
    check("R9 new len stored", regRdData, 32'h0000_0001);
    check("R8 extra total", extraPulses, 0);
    summary();
  end
endmodule